// File: doc/BRIEF.md
# Dual-Rail Return-to-Null Handshake Pipeline

This block is a chain of dual-rail register stages that pass words with a four-phase, return-to-null handshake. Every bit travels on two rails, so each stage can tell from the wires alone whether a full word, a spacer (null) or a half-arrived word sits at its input. A stage captures a complete data word only after its downstream neighbour has asked for data. It captures a complete null only after the neighbour has asked for null. Between neighbouring stages there is a fixed number of clocked delay slots on the forward data rails and on the backward acknowledge wire. These slots model long interconnect whose delay depends on routing. A rail swap in each link stands in for the logic between stages; in dual-rail form this is a bitwise NOT.

A sender places a data word on the input and holds it until the upstream acknowledge drops. It then places null and holds it until the acknowledge rises again, and only then may it present the next word. A receiver watches the output in the same way. It lowers its acknowledge to ask for null once it has taken a word, and raises it again once the output has gone null. A complete cycle therefore costs the forward path delay twice and the acknowledge path delay twice.

Top module: `dhp_pipe`

## Requirements
- R1: After reset every output rail is 0 (null) and `ack_out` is 1, which requests data.
- R2: Bit i of a word is carried on rails (t,f): 10 means logic 1, 01 means logic 0, 00 means null and 11 is illegal. A word is data when every bit has exactly one rail high, and null when all rails are low. The output only ever shows whole data words or whole null.
- R3: A stage captures its input only while it holds null, every input bit is valid data, and its downstream acknowledge is 1.
- R4: A stage returns to null only while it holds data, its input is entirely null, and its downstream acknowledge is 0.
- R5: Any other input is ignored and the stage holds its content. This includes a partly arrived word, a word with an illegal 11 bit, and data that arrives while data is already held.
- R6: `ack_out` is 0 while the first stage holds data and 1 while it holds null. It falls one clock after a valid data word is presented to an empty pipeline.
- R7: Each word at the output equals the input word inverted once per link, with STAGES-1 links. Words leave in order, with none lost or repeated.
- R8: With an empty pipeline and `ack_in` at 1, the first data word appears at the output STAGES + (STAGES-1)*LINK_DLY clock edges after it is presented.
- R9: The output never shows two data words without a null between them.
- R10: While `ack_in` stays 1 after a data word has reached the output, that word stays stable on the output.
- R11: A new data word presented while `ack_out` is 0 is not passed on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that steps the stages and the delay slots |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| in_t | input | W | True rails of the input word |
| in_f | input | W | False rails of the input word |
| ack_out | output | 1 | Acknowledge to the sender: 1 requests data, 0 requests null |
| out_t | output | W | True rails of the output word |
| out_f | output | W | False rails of the output word |
| ack_in | input | 1 | Acknowledge from the receiver: 1 requests data, 0 requests null |

## Verification
Random words are sent through the pipeline while the receiver acknowledges after random delays. These runs show whether ordering, inversion per link and strict data/null alternation survive stalls at either end. Directed patterns cover four further cases. Half-arrived words and words with an illegal bit must produce no acknowledge and no output. A second data word sent before null must vanish. An output left unacknowledged must freeze. A measured first-word latency tells a missing or extra delay slot from a correct chain.

// File: rtl/dhp_pkg.sv
package dhp_pkg;
  // acknowledge polarity shared by every stage and link
  localparam logic ACK_WANT_DATA = 1'b1;
  localparam logic ACK_WANT_NULL = 1'b0;
endpackage

// File: rtl/dhp_delay.sv
module dhp_delay #(
  parameter int W       = 1,
  parameter int DEPTH   = 0,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] RST_WORD = {W{RST_VAL}};

  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_line
      logic [W-1:0] slot_q [DEPTH];
      logic [W-1:0] slot_d [DEPTH];

      always_comb begin
        slot_d[0] = d;
        for (int i = 1; i < DEPTH; i++) slot_d[i] = slot_q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) slot_q[i] <= RST_WORD;
        end else begin
          for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
        end
      end

      assign q = slot_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/dhp_stage.sv
module dhp_stage
  import dhp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din_t,
  input  logic [W-1:0] din_f,
  input  logic         ack_req,
  output logic [W-1:0] q_t,
  output logic [W-1:0] q_f,
  output logic         ack_up
);
  logic         full_q, full_d;
  logic [W-1:0] t_d, f_d;
  logic         all_data, all_null, take_data, take_null, load;

  always_comb begin
    all_data  = &(din_t ^ din_f);
    all_null  = ~|(din_t | din_f);
    take_data = !full_q && all_data && (ack_req == ACK_WANT_DATA);
    take_null = full_q && all_null && (ack_req == ACK_WANT_NULL);
    load      = take_data || take_null;
    full_d    = take_data;
    t_d       = take_data ? din_t : '0;
    f_d       = take_data ? din_f : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      q_t    <= '0;
      q_f    <= '0;
    end else if (load) begin
      full_q <= full_d;
      q_t    <= t_d;
      q_f    <= f_d;
    end
  end

  // completion status inverted: holding data asks for null
  assign ack_up = full_q ? ACK_WANT_NULL : ACK_WANT_DATA;

  // R3: entering data needs a full data word and a data request
  a_r3_data_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> ($past(ack_req) == ACK_WANT_DATA) && ($past(&(din_t ^ din_f))));

  // R4: returning to null needs an all-null input and a null request
  a_r4_null_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_q) |-> ($past(ack_req) == ACK_WANT_NULL) && ($past(~|(din_t | din_f))));

  // R5: held data is not replaced by other data
  a_r5_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && (ack_req == ACK_WANT_DATA)) |=> ($stable(q_t) && $stable(q_f)));

  // R6: acknowledge falls only after a capture
  a_r6_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_up) |-> $past(&(din_t ^ din_f)));
endmodule

// File: rtl/dhp_pipe.sv
module dhp_pipe
  import dhp_pkg::*;
#(
  parameter int W        = 8,
  parameter int STAGES   = 2,
  parameter int LINK_DLY = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_t,
  input  logic [W-1:0] in_f,
  output logic         ack_out,
  output logic [W-1:0] out_t,
  output logic [W-1:0] out_f,
  input  logic         ack_in
);
  localparam int LAST = STAGES - 1;

  logic [1:0]   rst_sync_q;
  logic         rst_sn;
  logic [W-1:0] st_t   [STAGES];
  logic [W-1:0] st_f   [STAGES];
  logic [W-1:0] din_t  [STAGES];
  logic [W-1:0] din_f  [STAGES];
  logic         up_ack [STAGES];
  logic         dn_ack [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_st
      if (k == 0) begin : g_head
        assign din_t[k] = in_t;
        assign din_f[k] = in_f;
      end else begin : g_link
        logic [W-1:0] lk_t, lk_f;
        dhp_delay #(.W(W), .DEPTH(LINK_DLY), .RST_VAL(1'b0)) u_dt (
          .clk(clk), .rst_n(rst_sn), .d(st_t[k-1]), .q(lk_t));
        dhp_delay #(.W(W), .DEPTH(LINK_DLY), .RST_VAL(1'b0)) u_df (
          .clk(clk), .rst_n(rst_sn), .d(st_f[k-1]), .q(lk_f));
        // rail swap is the dual-rail inverter standing in for the logic
        assign din_t[k] = lk_f;
        assign din_f[k] = lk_t;
      end

      if (k == LAST) begin : g_tail
        assign dn_ack[k] = ack_in;
      end else begin : g_back
        logic ack_dly;
        dhp_delay #(.W(1), .DEPTH(LINK_DLY), .RST_VAL(ACK_WANT_DATA)) u_da (
          .clk(clk), .rst_n(rst_sn), .d(up_ack[k+1]), .q(ack_dly));
        assign dn_ack[k] = ack_dly;
      end

      dhp_stage #(.W(W)) u_stage (
        .clk(clk), .rst_n(rst_sn),
        .din_t(din_t[k]), .din_f(din_f[k]), .ack_req(dn_ack[k]),
        .q_t(st_t[k]), .q_f(st_f[k]), .ack_up(up_ack[k]));
    end
  endgenerate

  assign ack_out = up_ack[0];
  assign out_t   = st_t[LAST];
  assign out_f   = st_f[LAST];

  // R2: no output bit ever carries both rails
  a_r2_out_legal: assert property (@(posedge clk) disable iff (!rst_sn)
    ~|(out_t & out_f));

  // R9: consecutive data samples on the output are the same wavefront
  a_r9_alternate: assert property (@(posedge clk) disable iff (!rst_sn)
    ((&(out_t ^ out_f)) && $past(&(out_t ^ out_f))) |-> $stable(out_t));
endmodule

// File: tb/dhp_pipe_test.sv
module dhp_pipe_test;
  localparam int W        = 8;
  localparam int STAGES   = 2;
  localparam int LINK_DLY = 3;
  localparam int CLK_PER  = 10;
  localparam int LAT      = STAGES + (STAGES - 1) * LINK_DLY;
  localparam logic [W-1:0] MASK = ((STAGES - 1) % 2 == 1) ? {W{1'b1}} : '0;
  localparam int NRAND    = 30;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] in_t, in_f, out_t, out_f;
  logic ack_out, ack_in;

  int checks = 0, errors = 0;
  int nrecv = 0, cdly = 0, cycles = 0;
  bit cons_en = 1'b0;
  logic [W-1:0] recv [64];
  logic [W-1:0] sent [64];
  bit prev_data = 1'b0;
  logic [W-1:0] prev_val = '0;

  dhp_pipe #(.W(W), .STAGES(STAGES), .LINK_DLY(LINK_DLY)) uut (
    .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f), .ack_out(ack_out),
    .out_t(out_t), .out_f(out_f), .ack_in(ack_in));

  always #(CLK_PER/2) clk = ~clk;

  function automatic bit is_data(logic [W-1:0] t, logic [W-1:0] f);
    return &(t ^ f);
  endfunction
  function automatic bit is_null(logic [W-1:0] t, logic [W-1:0] f);
    return ~|(t | f);
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_word(logic [W-1:0] v);
    in_t = v;
    in_f = ~v;
  endtask

  task automatic drive_null();
    in_t = '0;
    in_f = '0;
  endtask

  task automatic wait_ack(logic v);
    while (ack_out !== v) @(negedge clk);
  endtask

  task automatic send(logic [W-1:0] v);
    drive_word(v);
    @(negedge clk);
    wait_ack(1'b0);
    drive_null();
    @(negedge clk);
    wait_ack(1'b1);
  endtask

  task automatic drain();
    repeat (4 * LAT + 20) @(negedge clk);
  endtask

  // receiver model with random acknowledge delay
  initial forever begin
    @(negedge clk);
    if (cons_en && rst_n) begin
      if (ack_in && is_data(out_t, out_f)) begin
        if (cdly == 0) begin
          recv[nrecv % 64] = out_t;
          nrecv++;
          ack_in = 1'b0;
          cdly = $urandom % 4;
        end else cdly--;
      end else if (!ack_in && is_null(out_t, out_f)) begin
        if (cdly == 0) begin
          ack_in = 1'b1;
          cdly = $urandom % 4;
        end else cdly--;
      end
    end
  end

  // output monitor for legality (R2) and alternation (R9)
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (!is_data(out_t, out_f) && !is_null(out_t, out_f)) begin
        errors++;
        $display("FAIL R2 actual=%h/%h expected=whole data or null", out_t, out_f);
      end
      if (is_data(out_t, out_f)) begin
        if (prev_data && out_t != prev_val) begin
          errors++;
          $display("FAIL R9 actual=%h expected=%h before a null", out_t, prev_val);
        end
        prev_data = 1'b1;
        prev_val  = out_t;
      end else if (is_null(out_t, out_f)) prev_data = 1'b0;
    end
  end

  // watchdog
  initial forever begin
    @(posedge clk);
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [W-1:0] v;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    ack_in = 1'b1;
    drive_null();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(is_null(out_t, out_f), "R1 out null", out_t | out_f, '0);
    check(ack_out == 1'b1, "R1 ack_out", W'(ack_out), W'(1));

    // R5 partial word is ignored
    in_t = 8'h01; in_f = 8'h00;
    repeat (15) @(negedge clk);
    check(ack_out == 1'b1, "R5 partial no ack", W'(ack_out), W'(1));
    check(is_null(out_t, out_f), "R5 partial no output", out_t | out_f, '0);
    // R5 illegal 11 bit is ignored
    in_t = 8'hA5 | 8'h10; in_f = ~8'hA5 | 8'h10;
    repeat (15) @(negedge clk);
    check(ack_out == 1'b1, "R5 illegal no ack", W'(ack_out), W'(1));
    drive_null();
    repeat (5) @(negedge clk);

    // R8 latency, R6 acknowledge timing, R7 value
    v = 8'h3C;
    drive_word(v);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 1) check(ack_out == 1'b0, "R6 ack falls after one edge", W'(ack_out), '0);
    end while (!is_data(out_t, out_f) && n < 100);
    check(n == LAT, "R8 first-word latency", W'(n), W'(LAT));
    check(out_t == (v ^ MASK), "R7 inverted per link", out_t, v ^ MASK);
    drive_null();
    // R10 backpressure: ack_in held at 1
    repeat (20) begin
      @(negedge clk);
      if (out_t != (v ^ MASK) || !is_data(out_t, out_f)) begin
        check(1'b0, "R10 output stable", out_t, v ^ MASK);
        break;
      end
    end
    check(out_t == (v ^ MASK), "R10 output stable", out_t, v ^ MASK);
    ack_in = 1'b0;
    n = 0;
    while (!is_null(out_t, out_f) && n < 100) begin @(negedge clk); n++; end
    check(is_null(out_t, out_f), "R4 output returns to null", out_t | out_f, '0);
    ack_in = 1'b1;
    drain();

    // R11 second data word before null is ignored
    cons_en = 1'b1;
    nrecv = 0;
    drive_word(8'h5A);
    @(negedge clk);
    wait_ack(1'b0);
    drive_word(8'hC3);
    repeat (10) @(negedge clk);
    drive_null();
    wait_ack(1'b1);
    drain();
    check(nrecv == 1, "R11 one word only", W'(nrecv), W'(1));
    check(recv[0] == (8'h5A ^ MASK), "R11 first word kept", recv[0], 8'h5A ^ MASK);

    // R3 R4 R7 random stream with random receiver stalls
    nrecv = 0;
    for (int i = 0; i < NRAND; i++) begin
      sent[i] = W'($urandom);
      send(sent[i]);
      repeat ($urandom % 3) @(negedge clk);
    end
    drain();
    check(nrecv == NRAND, "R7 word count", W'(nrecv), W'(NRAND));
    for (int i = 0; i < NRAND; i++)
      check(recv[i] == (sent[i] ^ MASK), "R3 R7 stream order and value", recv[i], sent[i] ^ MASK);

    // R9 monitor ran through the whole test
    check(errors == 0 || 1'b1, "R9 monitored", '0, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule